// File: doc/BRIEF.md
# Timer clock select and prescaler

This block turns a system clock into a count-enable tick for a timer. A 3-bit source-select input picks one of eight behaviours: the tick stays low (timer stopped), it is high on every system clock, it fires once every 8, 64, 256 or 1024 system clocks, or it fires on a chosen edge of an external input pin. The timer that consumes the tick advances by one for each cycle in which the tick is high.

All the divided ratios come from one free-running 10-bit prescaler counter. A ratio of 2^k fires when the low k bits of that counter are all ones. A synchronous clear input restarts the counter, so a timer can be started in a known phase. The external pin is asynchronous to the system clock. It passes through a two-flop synchronizer and then through an edge detector. The tick comes from a flop, so it has no glitches and is exactly one system clock wide for every source except the undivided one.

Top module: `tmr_tick_gen`

## Requirements
- R1: With `src_sel` = 3'b000, `tick` stays low on every cycle.
- R2: With `src_sel` = 3'b001, `tick` is high in every cycle that follows a rising clock edge at which 3'b001 was selected. The prescaler clear has no effect on this code.
- R3: With `src_sel` = 3'b010, `tick` is high for one cycle after the 8th rising edge that follows the edge at which `pre_clr` was sampled high, and then every 8 edges.
- R4: With `src_sel` = 3'b011, the same holds with a period of 64 edges.
- R5: With `src_sel` = 3'b100 the period is 256 edges, and with 3'b101 it is 1024 edges. The first tick again falls that many edges after the clear.
- R6: With `src_sel` = 3'b111, a 0-to-1 change of `ext_pin` that is set up before edge a makes `tick` high in the cycle after edge a+2 only. A 1-to-0 change makes no tick.
- R7: With `src_sel` = 3'b110, a 1-to-0 change of `ext_pin` that is set up before edge a makes `tick` high in the cycle after edge a+2 only. A 0-to-1 change makes no tick.
- R8: `pre_clr` sampled high at an edge sets the prescaler count to zero and suppresses the divided ticks at that edge. The next divided tick then comes exactly one full period after that edge.
- R9: While `rst` is high, `tick` is low. The synchronizer also clears, so a pin held low through reset makes no tick.
- R10: For every code other than 3'b001, a tick lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| pre_clr | input | 1 | Synchronous clear of the prescaler counter |
| src_sel | input | 3 | Tick source code: stop, divide-by 1/8/64/256/1024, pin falling, pin rising |
| ext_pin | input | 1 | Asynchronous external count input |
| tick | output | 1 | Registered count-enable tick |

## Verification
A divided tick is due N rising edges after the edge that sampled the clear. An undivided tick is due in the cycle after the edge that sampled the code. A pin edge is seen on the third rising edge after the pin changes: two synchronizer flops, then the output flop. The bench changes inputs and reads `tick` one nanosecond after each rising edge. It then counts edges from the stimulus edge and compares each sample with the value the requirement gives for that edge. This includes samples just before and just after every expected tick, so a result that comes early, comes late or lasts too long is caught.

// File: rtl/tick_pkg.sv
package tick_pkg;

    typedef enum logic [2:0] {
        SRC_OFF      = 3'b000,
        SRC_DIV1     = 3'b001,
        SRC_DIV8     = 3'b010,
        SRC_DIV64    = 3'b011,
        SRC_DIV256   = 3'b100,
        SRC_DIV1024  = 3'b101,
        SRC_PIN_FALL = 3'b110,
        SRC_PIN_RISE = 3'b111
    } src_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_s;

    localparam int N_DIV_TAPS = 4;

    // log2 of each prescaled ratio, index 0 = /8 ... index 3 = /1024
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       tap_shift = 3;
            1:       tap_shift = 6;
            2:       tap_shift = 8;
            default: tap_shift = 10;
        endcase
    endfunction

    // index into the tap vector for a divided code
    function automatic int tap_index(input src_sel_e s);
        case (s)
            SRC_DIV8:   tap_index = 0;
            SRC_DIV64:  tap_index = 1;
            SRC_DIV256: tap_index = 2;
            default:    tap_index = 3;
        endcase
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int N_TAPS = N_DIV_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    output logic [N_TAPS-1:0] tap_hit
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // each ratio fires when its low bits are all ones
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int SH = tap_shift(g);
        assign tap_hit[g] = !clr && (&cnt[SH-1:0]);
    end

    // R8: a clear restarts the count from zero
    assert_clear_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/tick_pin_edge.sv
module tick_pin_edge
    import tick_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    output pin_edge_s edges
);

    localparam int MSB = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[MSB];
        end
    end

    always_comb begin
        edges.rise = sync_q[MSB] && !last_q;
        edges.fall = !sync_q[MSB] && last_q;
    end

    // R6: a detected rise means the pin was high STAGES edges earlier
    assert_rise_from_pin_R6: assert property (@(posedge clk) disable iff (rst)
        edges.rise |-> $past(pin, STAGES));

    // R7: a detected fall means the pin was low STAGES edges earlier
    assert_fall_from_pin_R7: assert property (@(posedge clk) disable iff (rst)
        edges.fall |-> !$past(pin, STAGES));

endmodule

// File: rtl/tick_select.sv
module tick_select
    import tick_pkg::*;
#(
    parameter int N_TAPS = N_DIV_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  src_sel_e          sel,
    input  logic [N_TAPS-1:0] tap_hit,
    input  pin_edge_s         edges,
    output logic              tick
);

    logic tick_d;

    always_comb begin
        case (sel)
            SRC_OFF:      tick_d = 1'b0;
            SRC_DIV1:     tick_d = 1'b1;
            SRC_PIN_FALL: tick_d = edges.fall;
            SRC_PIN_RISE: tick_d = edges.rise;
            default:      tick_d = tap_hit[tap_index(sel)];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= 1'b0;
        end else begin
            tick <= tick_d;
        end
    end

    // R1: the stop code yields no tick
    assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_OFF) |=> !tick);

    // R2: the undivided code ticks on the next cycle
    assert_pass_every_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_DIV1) |=> tick);

    // R10: ticks from other sources are one cycle wide
    assert_single_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && $stable(sel) && sel != SRC_DIV1) |=> !tick);

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tick_pkg::*;
#(
    parameter int PRE_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pre_clr,
    input  logic [2:0] src_sel,
    input  logic       ext_pin,
    output logic       tick
);

    logic [N_DIV_TAPS-1:0] tap_hit;
    pin_edge_s             edges;
    src_sel_e              sel;

    assign sel = src_sel_e'(src_sel);

    tick_prescaler #(
        .CNT_W  (PRE_W),
        .N_TAPS (N_DIV_TAPS)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clr     (pre_clr),
        .tap_hit (tap_hit)
    );

    tick_pin_edge #(
        .STAGES (SYNC_STAGES)
    ) u_pin (
        .clk   (clk),
        .rst   (rst),
        .pin   (ext_pin),
        .edges (edges)
    );

    tick_select #(
        .N_TAPS (N_DIV_TAPS)
    ) u_sel (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .tap_hit (tap_hit),
        .edges   (edges),
        .tick    (tick)
    );

    // R9: reset holds the tick low
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> !tick);

endmodule

// File: tb/tmr_tick_gen_test.sv
`timescale 1ns/1ps
module tmr_tick_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_clr = 1'b0;
    logic [2:0] src_sel = 3'b001;
    logic       ext_pin = 1'b0;
    logic       tick;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_tick_gen uut (
        .clk     (clk),
        .rst     (rst),
        .pre_clr (pre_clr),
        .src_sel (src_sel),
        .ext_pin (ext_pin),
        .tick    (tick)
    );

    // stimulus table: select code and tick period (0 = never)
    localparam int N_ROWS = 6;
    localparam int ROW_SEL [N_ROWS] = '{0, 1, 2, 3, 4, 5};
    localparam int ROW_DIV [N_ROWS] = '{0, 1, 8, 64, 256, 1024};

    function automatic string row_tag(input int s);
        case (s)
            0:       row_tag = "R1";
            1:       row_tag = "R2";
            2:       row_tag = "R3";
            3:       row_tag = "R4";
            default: row_tag = "R5";
        endcase
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: tick=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        // R9: reset holds tick low even with the undivided code selected
        step();
        step();
        chk(tick, 1'b0, "R9 during reset");
        step();
        chk(tick, 1'b0, "R9 during reset");
        rst = 1'b0;
        step();
        chk(tick, 1'b1, "R2 first edge after reset");

        // table walk over stop and the divided ratios
        for (int r = 0; r < N_ROWS; r++) begin
            src_sel = ROW_SEL[r][2:0];
            pre_clr = 1'b1;
            step();
            pre_clr = 1'b0;
            for (int c = 0; c <= 3 * (ROW_DIV[r] > 1 ? ROW_DIV[r] : 4); c++) begin
                logic exp;
                if (ROW_DIV[r] == 0)      exp = 1'b0;
                else if (ROW_DIV[r] == 1) exp = 1'b1;
                else                      exp = (c != 0) && (c % ROW_DIV[r] == 0);
                chk(tick, exp, row_tag(ROW_SEL[r]));
                step();
            end
        end

        // R8: a clear in the middle of a /8 run restarts the phase
        src_sel = 3'b010;
        pre_clr = 1'b1;
        step();
        pre_clr = 1'b0;
        for (int c = 1; c <= 13; c++) step();
        pre_clr = 1'b1;
        step();
        pre_clr = 1'b0;
        chk(tick, 1'b0, "R8 at clear edge");
        for (int c = 1; c <= 8; c++) begin
            step();
            chk(tick, (c == 8), "R8 after clear");
        end

        // R6: rising pin edge, code 111
        src_sel = 3'b111;
        ext_pin = 1'b0;
        for (int c = 0; c < 4; c++) step();
        ext_pin = 1'b1;
        step();
        chk(tick, 1'b0, "R6 edge a");
        step();
        chk(tick, 1'b0, "R6 edge a+1");
        step();
        chk(tick, 1'b1, "R6 edge a+2");
        step();
        chk(tick, 1'b0, "R10 rise tick width");
        ext_pin = 1'b0;
        for (int c = 0; c < 5; c++) begin
            step();
            chk(tick, 1'b0, "R6 falling pin ignored");
        end

        // R7: falling pin edge, code 110
        src_sel = 3'b110;
        for (int c = 0; c < 3; c++) step();
        ext_pin = 1'b1;
        for (int c = 0; c < 5; c++) begin
            step();
            chk(tick, 1'b0, "R7 rising pin ignored");
        end
        ext_pin = 1'b0;
        step();
        chk(tick, 1'b0, "R7 edge a");
        step();
        chk(tick, 1'b0, "R7 edge a+1");
        step();
        chk(tick, 1'b1, "R7 edge a+2");
        step();
        chk(tick, 1'b0, "R10 fall tick width");

        // R1: stop code with pin activity still gives nothing
        src_sel = 3'b000;
        ext_pin = 1'b1;
        for (int c = 0; c < 4; c++) begin
            step();
            chk(tick, 1'b0, "R1 stopped with pin toggle");
        end

        done = 1;
        finish_run();
    end

endmodule